// File: doc/BRIEF.md
# Divided Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. Software reaches it through a small register port with separate write and read strobes. There are three registers: a divide configuration, an initial count and a current count. A prescaler turns the core clock into count ticks. Each tick lasts sixteen core cycles times a divisor, and the divisor comes from a 3-bit code.

A write to the initial count register starts a countdown from the written value. The countdown uses the divisor that is in effect at the moment of that write. Reading the current count gives the number of ticks that have not yet completed. When the last tick completes, the block raises a one-cycle expiry pulse and parks the count at zero. Interrupt delivery and any repeating modes belong to the logic around the block.

Top module: `cdt_timer`

## Requirements
- R1: Register select `addr` uses 0 for divide configuration, 1 for initial count and 2 for current count. The divide configuration keeps only bits 3, 1 and 0 of a write. Every other bit reads back as zero.
- R2: The divide code is {cfg[3], cfg[1], cfg[0]}. The shift is (code + 1) mod 8. One tick lasts 16 << shift core cycles, so code 000 gives 32 cycles and code 111 gives 16.
- R3: A write of N to the initial count stores all bits, and N reads back at address 1. In the cycle after the write edge the current count reads N.
- R4: While counting, the current count falls by one at the end of each completed tick. After P cycles it reads N-1.
- R5: Exactly N*P cycles after the initial-count write edge, `expire` is high for one cycle. The current count then stays at zero.
- R6: Writes to the current count register change nothing.
- R7: An initial-count write of zero leaves the timer idle with the current count at zero. No expiry pulse follows.
- R8: Changing the divide configuration during a countdown leaves the running countdown's tick length unchanged.
- R9: Reset clears all three registers and `expire`, and stops any countdown in progress.
- R10: A new initial-count write during a countdown restarts it. Expiry then comes N*P cycles after the new write, with no earlier pulse.
- R11: `rdata` is zero when `rd_en` is low or when address 3 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, combinational by default |
| expire | output | 1 | One-cycle pulse when the countdown reaches zero |

## Verification
If the prescaler period or the latched shift goes wrong, the expiry pulse arrives at the wrong cycle count. It also shows up as a mid-run read that does not equal N-1 when the first tick is over, so a single tick exposes it. A stuck or mis-stepped count is visible on the next current-count read. A missing idle state shows up as a second pulse, or as a pulse after a zero load, within one tick period. Mask errors in the divide register show on the read that directly follows the write.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   typedef enum logic [1:0] {
      SEL_DIV  = 2'd0,
      SEL_INIT = 2'd1,
      SEL_CUR  = 2'd2,
      SEL_NONE = 2'd3
   } cdt_sel_e;

   localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/cdt_div_decode.sv
module cdt_div_decode #(
   parameter int unsigned SHIFT_W = 3
) (
   input  logic [SHIFT_W-1:0] code,
   output logic [SHIFT_W-1:0] shift
);
   // wrap-around increment: the all-ones code maps to shift zero
   always_comb shift = code + SHIFT_W'(1);
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
   parameter int unsigned BASE_LOG2 = 4,
   parameter int unsigned SHIFT_W   = 3,
   localparam int unsigned PW       = BASE_LOG2 + (1 << SHIFT_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               run,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   logic [PW-1:0] pre_q;
   logic [PW-1:0] last;

   always_comb begin
      last = (PW'(1) << (BASE_LOG2 + 32'(shift))) - PW'(1);
      tick = run && (pre_q == last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pre_q <= '0;
      else if (clear || !run) pre_q <= '0;
      else if (tick)          pre_q <= '0;
      else                    pre_q <= pre_q + PW'(1);
   end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             active,
   output logic             expire
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
         expire <= 1'b0;
      end else if (load) begin
         cnt    <= load_val;
         active <= |load_val;
         expire <= 1'b0;
      end else if (active && tick) begin
         cnt    <= cnt - CNT_W'(1);
         active <= (cnt != CNT_W'(1));
         expire <= (cnt == CNT_W'(1));
      end else begin
         expire <= 1'b0;
      end
   end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned BASE_LOG2 = 4,
   parameter bit          READ_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             expire
);
   import cdt_pkg::*;
   localparam int unsigned SW = CODE_W;

   if (CNT_W < 4)     $error("cdt_timer: CNT_W must be at least 4");
   if (BASE_LOG2 > 8) $error("cdt_timer: BASE_LOG2 out of range");

   logic [SW-1:0]    code_q;
   logic [SW-1:0]    live_shift;
   logic [SW-1:0]    run_shift_q;
   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] cnt_w;
   logic             active_w;
   logic             tick_w;
   logic             load_w;
   logic [CNT_W-1:0] rd_mux;

   assign load_w = wr_en && (cdt_sel_e'(addr) == SEL_INIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q      <= '0;
         init_q      <= '0;
         run_shift_q <= '0;
      end else if (wr_en) begin
         case (cdt_sel_e'(addr))
            SEL_DIV:  code_q <= {wdata[3], wdata[1:0]};
            SEL_INIT: begin
               init_q      <= wdata;
               run_shift_q <= live_shift;
            end
            default: ;
         endcase
      end
   end

   cdt_div_decode #(.SHIFT_W(SW)) u_dec (
      .code  (code_q),
      .shift (live_shift)
   );

   cdt_prescaler #(.BASE_LOG2(BASE_LOG2), .SHIFT_W(SW)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load_w),
      .run   (active_w),
      .shift (run_shift_q),
      .tick  (tick_w)
   );

   cdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_w),
      .load_val (wdata),
      .tick     (tick_w),
      .cnt      (cnt_w),
      .active   (active_w),
      .expire   (expire)
   );

   always_comb begin
      rd_mux = '0;
      if (rd_en) begin
         case (cdt_sel_e'(addr))
            SEL_DIV:  rd_mux = CNT_W'({code_q[2], 1'b0, code_q[1:0]});
            SEL_INIT: rd_mux = init_q;
            SEL_CUR:  rd_mux = cnt_w;
            default:  rd_mux = '0;
         endcase
      end
   end

   if (READ_REG) begin : g_rd_reg
      logic [CNT_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign rdata = rd_q;
   end else begin : g_rd_comb
      assign rdata = rd_mux;
   end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] cur,
   input logic             active,
   input logic             expire
);
   logic init_wr;
   logic cur_wr;
   assign init_wr = wr_en && (addr == 2'd1);
   assign cur_wr  = wr_en && (addr == 2'd2);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   a_r5_zero_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (cur == '0) && !active);

   a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !init_wr) |=> (cur == $past(cur)) || (cur == $past(cur) - CNT_W'(1)));

   a_r6_cur_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_wr && !active) |=> $stable(cur));

   a_r7_zero_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (init_wr && (wdata == '0)) |=> (!active && !expire && (cur == '0)));
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .cur    (cnt_w),
   .active (active_w),
   .expire (expire)
);

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 9;
   localparam logic [31:0] V_CFG [NV] = '{32'hFFFF_FFFF, 32'h0, 32'h1, 32'h2, 32'h3,
                                         32'h8, 32'h9, 32'hA, 32'hFFFF_FFF4};
   localparam logic [31:0] V_STO [NV] = '{32'hB, 32'h0, 32'h1, 32'h2, 32'h3,
                                         32'h8, 32'h9, 32'hA, 32'h0};
   localparam int V_PER [NV] = '{16, 32, 64, 128, 256, 512, 1024, 2048, 32};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        expire;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   cdt_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .expire(expire));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   // waits maxc cycles, records the first cycle with expire high and the pulse count
   task automatic watch(input int maxc, output int first, output int hits);
      first = -1; hits = 0;
      for (int k = 1; k <= maxc; k++) begin
         @(negedge clk);
         if (expire) begin
            if (first < 0) first = k;
            hits++;
         end
      end
   endtask

   initial begin
      logic [31:0] d;
      int first, hits;
      repeat (3) @(negedge clk);
      // R9: reset state
      rd(2'd0, d); check("R9 div after reset", d, 32'h0);
      rd(2'd1, d); check("R9 init after reset", d, 32'h0);
      rd(2'd2, d); check("R9 cur after reset", d, 32'h0);
      check("R9 expire after reset", {31'b0, expire}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R1, R2, R3, R4, R5
      for (int v = 0; v < NV; v++) begin
         wr(2'd0, V_CFG[v]);
         rd(2'd0, d); check("R1 div mask", d, V_STO[v]);
         @(negedge clk);
         wr(2'd1, 32'd2);
         rd(2'd1, d); check("R3 init readback", d, 32'd2);
         rd(2'd2, d); check("R3 cur after load", d, 32'd2);
         first = -1; hits = 0;
         for (int k = 1; k <= 2*V_PER[v] + 3; k++) begin
            @(negedge clk);
            if (expire) begin
               if (first < 0) first = k;
               hits++;
            end
            if (k == V_PER[v]) begin
               rd(2'd2, d); check("R4 cur after one tick", d, 32'd1);
            end
         end
         check("R2 R5 expiry cycle", first, 2*V_PER[v]);
         check("R5 single pulse", hits, 1);
         rd(2'd2, d); check("R5 cur holds zero", d, 32'd0);
      end

      // R6: write to current count ignored
      wr(2'd0, 32'hB);
      wr(2'd1, 32'd5);
      wr(2'd2, 32'h1234);
      rd(2'd2, d); check("R6 cur write ignored", d, 32'd5);
      wr(2'd1, 32'd0);

      // R7: zero load stays idle
      @(negedge clk);
      wr(2'd1, 32'd0);
      watch(200, first, hits);
      check("R7 no pulse on zero load", hits, 0);
      rd(2'd2, d); check("R7 cur zero", d, 32'd0);

      // R8: divider change mid-run (tick 16 latched, config moved to 32)
      wr(2'd0, 32'hB);
      wr(2'd1, 32'd2);
      wr(2'd0, 32'h0);
      watch(80, first, hits);
      check("R8 expiry with latched divisor", first, 31);
      check("R8 single pulse", hits, 1);

      // R10: restart during countdown (tick now 32)
      wr(2'd1, 32'd4);
      repeat (20) @(negedge clk);
      wr(2'd1, 32'd2);
      watch(80, first, hits);
      check("R10 expiry after restart", first, 64);
      check("R10 single pulse", hits, 1);

      // R11: no read strobe and unmapped address
      wr(2'd1, 32'd7);
      addr = 2'd1; rd_en = 1'b0;
      #1 check("R11 no strobe", rdata, 32'h0);
      rd(2'd3, d); check("R11 address 3", d, 32'h0);

      // R9: reset during a countdown
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(2'd2, d); check("R9 cur cleared", d, 32'h0);
      rd(2'd1, d); check("R9 init cleared", d, 32'h0);
      watch(600, first, hits);
      check("R9 no pulse after reset", hits, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule